// File: doc/BRIEF.md
# Byte-Symbol Two-Error Reed-Solomon Codec

This block protects memory data with a Reed-Solomon code over 8-bit symbols. Each protected block is 16 data bytes plus 4 check bytes. The block has two paths. A combinational encoder produces the 4 check bytes for a data block. A pipelined decoder takes a 20-byte received word, repairs any damage that falls in at most two byte positions, and reports how many bytes it changed.

When the damage is heavier and the syndromes do not fit a consistent repair of one or two bytes, the decoder raises a poison flag. In that case it passes the received data through unrepaired, so the data is never silently altered. A wide read is split into independent lanes, two by default, which gives two 16-byte halves. Each lane has its own check bytes, its own repair count and its own poison flag.

The decoder takes one word group per clock through a valid/ready handshake and has a fixed latency of three cycles. When the consumer withholds ready, the whole pipeline freezes.

Top module: `rs_byte_ecc`

## Requirements
- R1: Field arithmetic uses GF(2^8) with reduction polynomial 0x11D and alpha = 0x02. Codeword byte k (k = 0..19; bytes 0..15 are data, 16..19 are check) is the coefficient of x^(19-k). The check bytes make the codeword vanish at alpha^0, alpha^1, alpha^2 and alpha^3, so data bytes appear unchanged. Check byte 0 (codeword byte 16) is the x^3 coefficient. For data whose last byte is 0x01 and all other bytes 0, the check bytes are 0x0F, 0x36, 0x78, 0x40.
- R2: A received word with no damage returns its data bytes unchanged, with repair count 0 and poison 0.
- R3: Damage to any single byte position among the 20, with any nonzero error value, is fully repaired, and the repair count is 1.
- R4: Damage to any two distinct byte positions, with any values, is fully repaired, and the repair count is 2.
- R5: Damage confined to the check bytes leaves the data output equal to the original data. The repair count still reports the number of damaged check bytes.
- R6: With damage in three or more byte positions, each lane either raises poison (repair count 0, data output equal to the received data bytes) or reports a repair count of 1 or 2. Over many random heavy patterns, at least 90% raise poison.
- R7: Lanes are independent. Damage in one lane does not change the data, count or poison result of another lane.
- R8: A word group accepted on a clock edge appears at the outputs with out_valid after exactly three rising edges. Back-to-back groups come out on consecutive cycles.
- R9: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low. No group is lost or duplicated when ready returns.
- R10: After reset, out_valid and out_poison are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_data | input | LANES*DATA_BYTES*8 | Data to encode; lane l byte k at bits [(l*DATA_BYTES+k)*8 +: 8] |
| enc_check | output | LANES*32 | Check bytes; lane l check byte m at bits [(l*4+m)*8 +: 8] |
| in_valid | input | 1 | Received word group is present |
| in_ready | output | 1 | Decoder can take a group this cycle |
| in_word | input | LANES*(DATA_BYTES+4)*8 | Received words; lane l byte k at bits [(l*(DATA_BYTES+4)+k)*8 +: 8] |
| out_valid | output | 1 | Decoded group is present |
| out_ready | input | 1 | Consumer takes the decoded group |
| out_data | output | LANES*DATA_BYTES*8 | Repaired data, same packing as enc_data |
| out_nfix | output | LANES*2 | Per-lane count of repaired bytes (0..2) |
| out_poison | output | LANES | Per-lane uncorrectable flag |

## Verification
The hardest case to reach from the ports is a heavy fault that the decoder takes for a valid one- or two-byte repair. This is a miscorrection, and it happens for only a small fraction of patterns. The bench drives a large set of random three- to six-byte faults. It accepts either outcome only in its legal form and requires poison to dominate. Two further cases need deliberate stimulus: two-byte repairs that fall entirely inside the check bytes, and a stall that freezes a second group in the middle stage. The bench targets both, along with a mixed-lane case that pairs a repairable lane with a heavy one.

// File: rtl/rs_pkg.sv
// Shared GF(2^8) arithmetic for the byte-symbol Reed-Solomon codec.
// Assumes reduction polynomial 0x11D and alpha = 0x02.
package rs_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CHK_BYTES = 4;

    typedef logic [7:0] gf_t;

    // Carry-less multiply with reduction by 0x11D.
    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1D : 8'h00);
        end
        return acc;
    endfunction

    // Inverse as a^254 by repeated squaring (inverse of 0 yields 0).
    function automatic gf_t gf_inv(gf_t a);
        gf_t sq;
        gf_t r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    // alpha raised to e, modulo the group order 255.
    function automatic gf_t gf_apow(int unsigned e);
        int unsigned m;
        gf_t r;
        gf_t b;
        m = e % 255;
        r = 8'h01;
        b = 8'h02;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) r = gf_mul(r, b);
            b = gf_mul(b, b);
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_syndrome.sv
// Evaluates a received word at alpha^0..alpha^3 (Horner form).
// Byte 0 of the word is the highest-degree coefficient. Purely combinational.
module rs_syndrome import rs_pkg::*; #(
    parameter int CW_BYTES = 20
) (
    input  logic [CW_BYTES*8-1:0]  word,
    output logic [CHK_BYTES*8-1:0] syn
);
    timeunit 1ns;
    timeprecision 1ps;

    // One Horner chain per root.
    for (genvar j = 0; j < CHK_BYTES; j++) begin : g_root
        localparam gf_t ROOT = gf_apow(j);
        always_comb begin : p_horner
            gf_t acc;
            acc = 8'h00;
            for (int k = 0; k < CW_BYTES; k++) begin
                acc = gf_mul(acc, ROOT) ^ word[k*8 +: 8];
            end
            syn[j*8 +: 8] = acc;
        end
    end
endmodule

// File: rtl/rs_encoder.sv
// Systematic encoder: check bytes are the remainder of data*x^4 divided by
// g(x) = (x+1)(x+a)(x+a^2)(x+a^3) = x^4 + 0F x^3 + 36 x^2 + 78 x + 40.
// Assumes data byte 0 is the highest-degree coefficient. Combinational.
module rs_encoder import rs_pkg::*; #(
    parameter int DATA_BYTES = 16
) (
    input  logic [DATA_BYTES*8-1:0] data,
    output logic [CHK_BYTES*8-1:0]  check
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam gf_t G0 = 8'h40;
    localparam gf_t G1 = 8'h78;
    localparam gf_t G2 = 8'h36;
    localparam gf_t G3 = 8'h0F;

    // Shift each data byte through a four-stage division register.
    always_comb begin : p_divide
        gf_t r0, r1, r2, r3, fb;
        r0 = 8'h00; r1 = 8'h00; r2 = 8'h00; r3 = 8'h00;
        for (int k = 0; k < DATA_BYTES; k++) begin
            fb = data[k*8 +: 8] ^ r3;
            r3 = r2 ^ gf_mul(fb, G3);
            r2 = r1 ^ gf_mul(fb, G2);
            r1 = r0 ^ gf_mul(fb, G1);
            r0 = gf_mul(fb, G0);
        end
        check = {r0, r1, r2, r3};
    end
endmodule

// File: rtl/rs_lane_decoder.sv
// One lane of the decoder, three register stages advanced together by adv:
// stage 1 holds syndromes, stage 2 holds the solved locator, and the output
// stage holds repaired data. Assumes the caller tracks validity (v1, v2).
module rs_lane_decoder import rs_pkg::*; #(
    parameter int DATA_BYTES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  adv,
    input  logic                                  v1,
    input  logic                                  v2,
    input  logic [(DATA_BYTES+CHK_BYTES)*8-1:0]   in_word,
    output logic [DATA_BYTES*8-1:0]               out_data,
    output logic [1:0]                            out_nfix,
    output logic                                  out_poison
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW_BYTES = DATA_BYTES + CHK_BYTES;
    localparam int CWW      = CW_BYTES * 8;
    localparam int DW       = DATA_BYTES * 8;

    logic [CHK_BYTES*8-1:0] syn_c;
    logic [CWW-1:0]         cw1;
    logic [CHK_BYTES*8-1:0] syn1;

    rs_syndrome #(.CW_BYTES(CW_BYTES)) u_syn_in (.word(in_word), .syn(syn_c));

    // Stage 1: capture the word and its syndromes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw1  <= '0;
            syn1 <= '0;
        end else if (adv) begin
            cw1  <= in_word;
            syn1 <= syn_c;
        end
    end

    gf_t s0, s1, s2, s3, det, num1, num2, l1_c, l2_c, il1_c;
    logic [1:0] deg_c;
    logic       pz_c;

    assign s0 = syn1[7:0];
    assign s1 = syn1[15:8];
    assign s2 = syn1[23:16];
    assign s3 = syn1[31:24];

    // Direct solve of the locator for one or two errors, with consistency checks.
    always_comb begin
        det   = gf_mul(s1, s1) ^ gf_mul(s0, s2);
        num1  = gf_mul(s2, s1) ^ gf_mul(s3, s0);
        num2  = gf_mul(s2, s2) ^ gf_mul(s3, s1);
        l1_c  = 8'h00;
        l2_c  = 8'h00;
        il1_c = 8'h00;
        deg_c = 2'd0;
        pz_c  = 1'b0;
        if (syn1 != '0) begin
            if (det != 8'h00) begin
                l1_c  = gf_mul(num1, gf_inv(det));
                l2_c  = gf_mul(num2, gf_inv(det));
                il1_c = gf_mul(det, gf_inv(num1));
                deg_c = 2'd2;
                pz_c  = (num1 == 8'h00) || (num2 == 8'h00);
            end else begin
                l1_c  = gf_mul(s1, gf_inv(s0));
                deg_c = 2'd1;
                pz_c  = (s0 == 8'h00) || (s1 == 8'h00) ||
                        (gf_mul(s2, s2) != gf_mul(s1, s3));
            end
        end
    end

    logic [CWW-1:0] cw2;
    gf_t            s0_2, s1_2, l1_2, l2_2, il1_2;
    logic [1:0]     deg2;
    logic           pz2;

    // Stage 2: hold the locator, the inputs for error values and the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw2 <= '0; s0_2 <= '0; s1_2 <= '0; l1_2 <= '0; l2_2 <= '0;
            il1_2 <= '0; deg2 <= '0; pz2 <= 1'b0;
        end else if (adv) begin
            cw2 <= cw1; s0_2 <= s0; s1_2 <= s1; l1_2 <= l1_c; l2_2 <= l2_c;
            il1_2 <= il1_c; deg2 <= deg_c; pz2 <= pz_c;
        end
    end

    logic [CW_BYTES-1:0] hit;
    logic [CWW-1:0]      fixed_w;

    // Parallel root search over every valid position, with the error value per position.
    for (genvar k = 0; k < CW_BYTES; k++) begin : g_pos
        localparam int  E   = CW_BYTES - 1 - k;
        localparam gf_t XK  = gf_apow(E);
        localparam gf_t XI  = gf_apow(255 - E);
        localparam gf_t XI2 = gf_apow(2 * (255 - E));
        gf_t ev;
        gf_t yv;
        assign ev     = 8'h01 ^ gf_mul(l1_2, XI) ^ gf_mul(l2_2, XI2);
        assign hit[k] = (ev == 8'h00);
        assign yv     = (deg2 == 2'd1) ? s0_2
                                       : gf_mul(s1_2 ^ gf_mul(s0_2, l1_2 ^ XK), il1_2);
        assign fixed_w[k*8 +: 8] = cw2[k*8 +: 8] ^ (hit[k] ? yv : 8'h00);
    end

    logic poison3;
    assign poison3 = pz2 || ($countones(hit) != int'(deg2));

    // Output stage: repaired data, or raw data with poison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_nfix   <= '0;
            out_poison <= 1'b0;
        end else if (adv) begin
            if (poison3) begin
                out_data   <= cw2[DW-1:0];
                out_nfix   <= 2'd0;
                out_poison <= 1'b1;
            end else begin
                out_data   <= fixed_w[DW-1:0];
                out_nfix   <= deg2;
                out_poison <= 1'b0;
            end
        end
    end

    // Checker logic: a repair that is not flagged must land on a codeword.
    logic [CHK_BYTES*8-1:0] syn_fix;
    rs_syndrome #(.CW_BYTES(CW_BYTES)) u_syn_chk (.word(fixed_w), .syn(syn_fix));

    p_fix_is_codeword_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && adv && !poison3) |-> (syn_fix == '0));

    p_zero_syn_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && adv && (syn1 == '0)) |=> ((deg2 == 2'd0) && !pz2));
endmodule

// File: rtl/rs_byte_ecc.sv
// Top of the multi-lane byte-symbol Reed-Solomon codec. It holds the
// encoders, one decoder lane per half and the shared valid pipeline. The
// whole pipeline stalls when the output is held and not taken.
module rs_byte_ecc import rs_pkg::*; #(
    parameter int LANES      = 2,
    parameter int DATA_BYTES = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [LANES*DATA_BYTES*8-1:0]               enc_data,
    output logic [LANES*CHK_BYTES*8-1:0]                enc_check,
    input  logic                                        in_valid,
    output logic                                        in_ready,
    input  logic [LANES*(DATA_BYTES+CHK_BYTES)*8-1:0]   in_word,
    output logic                                        out_valid,
    input  logic                                        out_ready,
    output logic [LANES*DATA_BYTES*8-1:0]               out_data,
    output logic [LANES*2-1:0]                          out_nfix,
    output logic [LANES-1:0]                            out_poison
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CWW = (DATA_BYTES + CHK_BYTES) * 8;
    localparam int DW  = DATA_BYTES * 8;
    localparam int KW  = CHK_BYTES * 8;

    logic adv, v1, v2;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    // Valid bits move with the data registers of every lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rs_encoder #(.DATA_BYTES(DATA_BYTES)) u_enc (
            .data  (enc_data[l*DW +: DW]),
            .check (enc_check[l*KW +: KW])
        );
        rs_lane_decoder #(.DATA_BYTES(DATA_BYTES)) u_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv        (adv),
            .v1         (v1),
            .v2         (v2),
            .in_word    (in_word[l*CWW +: CWW]),
            .out_data   (out_data[l*DW +: DW]),
            .out_nfix   (out_nfix[l*2 +: 2]),
            .out_poison (out_poison[l])
        );
    end

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_nfix) && $stable(out_poison)));

    p_rise_after_pipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(v2));
endmodule

// File: tb/rs_byte_ecc_tb_top.sv
// Directed bench for rs_byte_ecc: one task per scenario, each checking its own results.
module rs_byte_ecc_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANES = 2;
    localparam int DB    = 16;
    localparam int CB    = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst_n, in_valid, in_ready, out_valid, out_ready;
    logic [LANES*DB*8-1:0]  enc_data, out_data;
    logic [LANES*32-1:0]    enc_check;
    logic [LANES*CB*8-1:0]  in_word;
    logic [LANES*2-1:0]     out_nfix;
    logic [LANES-1:0]       out_poison;

    rs_byte_ecc #(.LANES(LANES), .DATA_BYTES(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_check(enc_check),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_nfix(out_nfix), .out_poison(out_poison)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] gexp [0:254];
    int         glog [0:255];
    logic [7:0] gen  [0:4];
    logic [7:0] orig [LANES][CB];
    logic [7:0] rx   [LANES][CB];

    // Check recorder: counts every check and prints one FAIL line per miss.
    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return gexp[(glog[a] + glog[b]) % 255];
    endfunction

    // Builds log/antilog tables and the generator from its four roots.
    task automatic init_gf();
        logic [7:0] v = 8'h01;
        logic [7:0] nx [0:4];
        for (int i = 0; i < 255; i++) begin
            gexp[i] = v;
            glog[v] = i;
            v = v[7] ? ({v[6:0], 1'b0} ^ 8'h1D) : {v[6:0], 1'b0};
        end
        glog[0] = 0;
        gen[0] = 8'h01;
        for (int i = 1; i < 5; i++) gen[i] = 8'h00;
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 5; i++)
                nx[i] = gmul(gen[i], gexp[r]) ^ ((i > 0) ? gen[i-1] : 8'h00);
            for (int i = 0; i < 5; i++) gen[i] = nx[i];
        end
    endtask

    // Long division of data*x^4 by the generator; fills check bytes of orig.
    task automatic b_encode(input int l);
        logic [7:0] buff [CB];
        logic [7:0] c;
        for (int k = 0; k < CB; k++) buff[k] = (k < DB) ? orig[l][k] : 8'h00;
        for (int i = 0; i < DB; i++) begin
            c = buff[i];
            for (int j = 1; j <= 4; j++) buff[i+j] ^= gmul(gen[4-j], c);
        end
        for (int m = 0; m < 4; m++) orig[l][DB+m] = buff[DB+m];
    endtask

    function automatic logic [7:0] horner(int l, int j);
        logic [7:0] acc = 8'h00;
        for (int k = 0; k < CB; k++) acc = gmul(acc, gexp[j]) ^ orig[l][k];
        return acc;
    endfunction

    task automatic make_clean(input int l);
        for (int k = 0; k < DB; k++) orig[l][k] = 8'($urandom_range(255, 0));
        b_encode(l);
        for (int k = 0; k < CB; k++) rx[l][k] = orig[l][k];
    endtask

    task automatic inject(input int l, input int n, input int lo, input int hi);
        logic [CB-1:0] used = '0;
        int p;
        for (int i = 0; i < n; i++) begin
            do p = $urandom_range(hi, lo); while (used[p]);
            used[p] = 1'b1;
            rx[l][p] ^= 8'($urandom_range(255, 1));
        end
    endtask

    task automatic pack();
        for (int l = 0; l < LANES; l++)
            for (int k = 0; k < CB; k++) in_word[(l*CB+k)*8 +: 8] = rx[l][k];
    endtask

    function automatic logic [DB*8-1:0] exp_data(int l);
        logic [DB*8-1:0] d;
        for (int k = 0; k < DB; k++) d[k*8 +: 8] = orig[l][k];
        return d;
    endfunction

    function automatic logic [DB*8-1:0] raw_data(int l);
        logic [DB*8-1:0] d;
        for (int k = 0; k < DB; k++) d[k*8 +: 8] = rx[l][k];
        return d;
    endfunction

    // Sends one group and samples it three edges after acceptance (R8).
    task automatic run_block();
        @(negedge clk);
        pack();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 out_valid three cycles after accept", 256'(out_valid), 256'(1));
    endtask

    task automatic check_lane(input int l, input int n, input string tag);
        chk(out_data[l*DB*8 +: DB*8] == exp_data(l), {tag, " data"}, 256'(out_data[l*DB*8 +: DB*8]), 256'(exp_data(l)));
        chk(out_nfix[l*2 +: 2] == 2'(n), {tag, " repair count"}, 256'(out_nfix[l*2 +: 2]), 256'(n));
        chk(out_poison[l] == 1'b0, {tag, " poison"}, 256'(out_poison[l]), 256'(0));
    endtask

    // Legal outcome for heavy damage (R6); returns 1 when poisoned.
    task automatic heavy_outcome(input int l, output bit pz);
        pz = out_poison[l];
        if (pz) begin
            chk(out_nfix[l*2 +: 2] == 2'd0, "R6 poison repair count", 256'(out_nfix[l*2 +: 2]), 256'(0));
            chk(out_data[l*DB*8 +: DB*8] == raw_data(l), "R6 poison passes raw data", 256'(out_data[l*DB*8 +: DB*8]), 256'(raw_data(l)));
        end else begin
            chk(out_nfix[l*2 +: 2] != 2'd0, "R6 unflagged outcome claims a repair", 256'(out_nfix[l*2 +: 2]), 256'(1));
            $display("note: miscorrection counted on lane %0d", l);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", 256'(out_valid), 256'(0));
        chk(out_poison == '0, "R10 poison after reset", 256'(out_poison), 256'(0));
        chk(in_ready == 1'b1, "R10 in_ready after reset", 256'(in_ready), 256'(1));
    endtask

    task automatic t_encoder();
        logic [31:0] exp_chk;
        enc_data = '0;
        #1;
        chk(enc_check == '0, "R1 zero data gives zero check", 256'(enc_check), 256'(0));
        enc_data = '0;
        enc_data[15*8 +: 8] = 8'h01;
        enc_data[DB*8 + 15*8 +: 8] = 8'h01;
        #1;
        chk(enc_check == {32'h4078360F, 32'h4078360F}, "R1 known vector", 256'(enc_check), 256'({32'h4078360F, 32'h4078360F}));
        for (int t = 0; t < 10; t++) begin
            for (int l = 0; l < LANES; l++) begin
                make_clean(l);
                enc_data[l*DB*8 +: DB*8] = exp_data(l);
            end
            #1;
            for (int l = 0; l < LANES; l++) begin
                exp_chk = {orig[l][19], orig[l][18], orig[l][17], orig[l][16]};
                chk(enc_check[l*32 +: 32] == exp_chk, "R1 encoder check bytes", 256'(enc_check[l*32 +: 32]), 256'(exp_chk));
                for (int j = 0; j < 4; j++)
                    chk(horner(l, j) == 8'h00, "R1 codeword root", 256'(horner(l, j)), 256'(0));
            end
        end
    endtask

    task automatic t_clean();
        for (int t = 0; t < 10; t++) begin
            for (int l = 0; l < LANES; l++) make_clean(l);
            run_block();
            for (int l = 0; l < LANES; l++) check_lane(l, 0, "R2 clean word");
        end
    endtask

    task automatic t_single();
        for (int t = 0; t < 40; t++) begin
            for (int l = 0; l < LANES; l++) begin make_clean(l); inject(l, 1, 0, CB-1); end
            run_block();
            for (int l = 0; l < LANES; l++) check_lane(l, 1, "R3 single byte");
        end
    endtask

    task automatic t_double();
        for (int t = 0; t < 40; t++) begin
            for (int l = 0; l < LANES; l++) begin make_clean(l); inject(l, 2, 0, CB-1); end
            run_block();
            for (int l = 0; l < LANES; l++) check_lane(l, 2, "R4 two bytes");
        end
    endtask

    task automatic t_check_only();
        for (int t = 0; t < 10; t++) begin
            make_clean(0); inject(0, 1, DB, CB-1);
            make_clean(1); inject(1, 2, DB, CB-1);
            run_block();
            check_lane(0, 1, "R5 check byte only");
            check_lane(1, 2, "R5 two check bytes");
        end
    endtask

    task automatic t_heavy();
        int pz_cnt = 0;
        int trials = 0;
        bit pz;
        for (int t = 0; t < 150; t++) begin
            for (int l = 0; l < LANES; l++) begin make_clean(l); inject(l, $urandom_range(6, 3), 0, CB-1); end
            run_block();
            for (int l = 0; l < LANES; l++) begin
                heavy_outcome(l, pz);
                trials++;
                if (pz) pz_cnt++;
            end
        end
        chk(pz_cnt * 10 >= trials * 9, "R6 poison rate", 256'(pz_cnt), 256'(trials));
    endtask

    task automatic t_lanes();
        bit pz;
        for (int t = 0; t < 20; t++) begin
            int good = t % 2;
            int bad  = 1 - good;
            make_clean(good); inject(good, (t % 3), 0, CB-1);
            make_clean(bad);  inject(bad, 4, 0, CB-1);
            run_block();
            check_lane(good, t % 3, "R7 lane isolation");
            heavy_outcome(bad, pz);
        end
    endtask

    task automatic t_stream();
        logic [LANES*DB*8-1:0] expd [5];
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 2) chk(out_valid == 1'b0, "R8 nothing before three cycles", 256'(out_valid), 256'(0));
            if (i >= 3) begin
                chk(out_valid == 1'b1, "R8 back-to-back valid", 256'(out_valid), 256'(1));
                chk(out_data == expd[i-3], "R8 back-to-back data", 256'(out_data), 256'(expd[i-3]));
            end
            if (i < 5) begin
                for (int l = 0; l < LANES; l++) begin
                    make_clean(l); inject(l, 1, 0, CB-1);
                    expd[i][l*DB*8 +: DB*8] = exp_data(l);
                end
                pack();
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 stream drains", 256'(out_valid), 256'(0));
    endtask

    task automatic t_backpressure();
        logic [LANES*DB*8-1:0] ea, eb;
        repeat (2) @(negedge clk);
        for (int l = 0; l < LANES; l++) begin make_clean(l); inject(l, 2, 0, CB-1); ea[l*DB*8 +: DB*8] = exp_data(l); end
        pack(); in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin make_clean(l); eb[l*DB*8 +: DB*8] = exp_data(l); end
        pack();
        @(negedge clk);
        in_valid = 1'b0;
        for (int w = 0; w < 5; w++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R9 held valid", 256'(out_valid), 256'(1));
            chk(out_data == ea, "R9 held data", 256'(out_data), 256'(ea));
            chk(in_ready == 1'b0, "R9 in_ready low in stall", 256'(in_ready), 256'(0));
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b1 && out_data == eb, "R9 second group after release", 256'(out_data), 256'(eb));
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 no duplicate", 256'(out_valid), 256'(0));
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_word = '0; enc_data = '0;
        init_gf();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_encoder();
        t_clean();
        t_single();
        t_double();
        t_check_only();
        t_heavy();
        t_lanes();
        t_stream();
        t_backpressure();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule